// File: doc/BRIEF.md
# Real-Mode Address Translation Router

This block accepts a 16-bit segment and a 16-bit offset, forms a byte address by multiplying the segment by sixteen and adding the offset, and steers a single-byte read or write to the region of a fixed legacy memory map. The regions are low RAM, a read-only firmware ROM, a slice of extended RAM above 1 MB, and unmapped windows for display and expansion devices. Small on-chip arrays back the RAM and ROM regions. To keep the arrays small, the low RAM and the ROM are indexed by their low address bits, so addresses that differ only in higher bits alias onto the same byte.

A host drives a read or write strobe together with the segment, offset and write data. One cycle later `ready` rises and the registered read data is valid. An access that falls on a device window or beyond the extended slice raises a one-cycle `unmapped` pulse. A read there returns 0xFF, and a write there changes nothing. The ROM is filled through a separate load port that only works while reset is held. An address-line-20 enable decides whether the carry out of bit 19 wraps the address or reaches extended memory.

Top module: `rmAddrRouter`

## Requirements
- R1: The physical address is segment*16 + offset. Different segment/offset pairs naming the same address reach the same byte; for example, 0x1000:0x0000 and 0x0FFF:0x0010 both resolve to 0x10000.
- R2: Addresses 0x00000–0x9FFFF are low RAM, which reads and writes. The backing array is indexed by the low `LOW_AW` address bits (10 by default).
- R3: A read in 0xA0000–0xEFFFF returns 0xFF and raises `unmapped` for one cycle. A write there changes no storage and raises the same pulse.
- R4: A read in 0xF0000–0xFFFFF returns the ROM byte at the low `ROM_AW` address bits (8 by default). A write there completes with `ready`, does not raise `unmapped`, and leaves the ROM unchanged.
- R5: The ROM load port writes `romInitData` at `romInitAddr` only while `rstN` is low. Once reset is released, the port has no effect.
- R6: When `a20En` is 1, addresses from 0x100000 to 0x100000+2^`EXT_AW`-1 select extended RAM at index address−0x100000. Any higher address is unmapped, with the R3 behaviour.
- R7: When `a20En` is 0, the carry out of bit 19 is dropped. For example, 0xFFFF:0x0010 resolves to 0x00000 in low RAM.
- R8: `ready` is high exactly in the cycle after a cycle with a strobe, and low otherwise. `rdData` is registered, is updated only by reads, and holds its value across writes.
- R9: If `rdEn` and `wrEn` are high together, the access is a read and no storage is written.
- R10: After reset, `ready`, `unmapped` and `rdData` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| segIn | input | 16 | Segment value |
| offIn | input | 16 | Offset value |
| rdEn | input | 1 | Read strobe |
| wrEn | input | 1 | Write strobe |
| wrData | input | 8 | Write byte |
| a20En | input | 1 | Lets the bit-20 carry through to extended memory |
| romInitEn | input | 1 | ROM load enable (active only in reset) |
| romInitAddr | input | ROM_AW | ROM load index |
| romInitData | input | 8 | ROM load byte |
| rdData | output | 8 | Registered read byte |
| ready | output | 1 | Access complete, one cycle after the strobe |
| unmapped | output | 1 | One-cycle pulse for an access to an unmapped window |

## Verification
On every cycle, the assertions check the following:
- the one-cycle strobe-to-ready timing;
- that `unmapped` only appears together with `ready`;
- that a ROM write never pulses `unmapped`;
- that an unmapped read returns 0xFF;
- that the low and extended write strobes never fire together.

The address arithmetic, the aliasing of segment/offset pairs, the wrap controlled by `a20En`, the preservation of ROM contents after a write, and the load port being dead after reset depend on stored data. Only the bench's directed write-then-read scenarios can show these.

// File: rtl/rm_pkg.sv
package rm_pkg;
  typedef enum logic [1:0] {
    SEL_LOW  = 2'd0,
    SEL_ROM  = 2'd1,
    SEL_EXT  = 2'd2,
    SEL_NONE = 2'd3
  } rmSel_t;

  typedef struct packed {
    logic   acc;
    logic   isRd;
    logic   lowWr;
    logic   extWr;
    logic   romLoad;
    rmSel_t rdSel;
  } rmStrobes_t;

  localparam logic [20:0] LOW_END  = 21'h0A0000;
  localparam logic [20:0] EXT_BASE = 21'h100000;
endpackage

// File: rtl/rm_ctrl.sv
module rm_ctrl
  import rm_pkg::*;
#(
  parameter int EXT_AW = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        rdEn,
  input  logic        wrEn,
  input  logic        romInitEn,
  input  logic [20:0] physAddr,
  output rmStrobes_t  strb,
  output logic        ready,
  output logic        unmapped
);
  rmSel_t region;
  logic   accNow;
  logic   rdNow;

  always_comb begin
    if (physAddr < LOW_END)
      region = SEL_LOW;
    else if (!physAddr[20] && physAddr[19:16] == 4'hF)
      region = SEL_ROM;
    else if (physAddr[20] && ((physAddr[19:0] >> EXT_AW) == 20'd0))
      region = SEL_EXT;
    else
      region = SEL_NONE;
  end

  assign accNow = rstN && (rdEn || wrEn);
  assign rdNow  = rdEn;

  always_comb begin
    strb.acc     = accNow;
    strb.isRd    = rdNow;
    strb.lowWr   = accNow && !rdNow && (region == SEL_LOW);
    strb.extWr   = accNow && !rdNow && (region == SEL_EXT);
    strb.romLoad = !rstN && romInitEn;
    strb.rdSel   = region;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ready    <= 1'b0;
      unmapped <= 1'b0;
    end else begin
      ready    <= accNow;
      unmapped <= accNow && (region == SEL_NONE);
    end
  end

  p_ready_follows_r8: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn || wrEn) |=> ready);
  p_ready_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(rdEn || wrEn) |=> !ready);
  p_unmapped_with_ready_r3: assert property (@(posedge clk) disable iff (!rstN)
    unmapped |-> ready);
  p_rom_write_quiet_r4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !rdEn && !physAddr[20] && physAddr[19:16] == 4'hF) |=> !unmapped);
endmodule

// File: rtl/rm_datapath.sv
module rm_datapath
  import rm_pkg::*;
#(
  parameter int LOW_AW = 10,
  parameter int ROM_AW = 8,
  parameter int EXT_AW = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [15:0]       segIn,
  input  logic [15:0]       offIn,
  input  logic              a20En,
  input  logic [7:0]        wrData,
  input  logic [ROM_AW-1:0] romInitAddr,
  input  logic [7:0]        romInitData,
  input  rmStrobes_t        strb,
  output logic [20:0]       physAddr,
  output logic [7:0]        rdData
);
  localparam int LOW_DEPTH = 1 << LOW_AW;
  localparam int ROM_DEPTH = 1 << ROM_AW;
  localparam int EXT_DEPTH = 1 << EXT_AW;

  logic [7:0] lowMem [LOW_DEPTH];
  logic [7:0] romMem [ROM_DEPTH];
  logic [7:0] extMem [EXT_DEPTH];

  logic [20:0]       rawSum;
  logic [LOW_AW-1:0] lowIdx;
  logic [ROM_AW-1:0] romIdx;
  logic [EXT_AW-1:0] extIdx;
  logic [7:0]        rdMux;

  assign rawSum   = {1'b0, segIn, 4'b0000} + {5'b00000, offIn};
  assign physAddr = a20En ? rawSum : {1'b0, rawSum[19:0]};
  assign lowIdx   = physAddr[LOW_AW-1:0];
  assign romIdx   = physAddr[ROM_AW-1:0];
  assign extIdx   = physAddr[EXT_AW-1:0];

  always_ff @(posedge clk) begin
    if (strb.lowWr) lowMem[lowIdx] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (strb.extWr) extMem[extIdx] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (strb.romLoad) romMem[romInitAddr] <= romInitData;
  end

  always_comb begin
    case (strb.rdSel)
      SEL_LOW: rdMux = lowMem[lowIdx];
      SEL_ROM: rdMux = romMem[romIdx];
      SEL_EXT: rdMux = extMem[extIdx];
      default: rdMux = 8'hFF;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      rdData <= 8'h00;
    else if (strb.acc && strb.isRd)
      rdData <= rdMux;
  end

  p_unmapped_reads_ff_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.acc && strb.isRd && strb.rdSel == SEL_NONE) |=> rdData == 8'hFF);
  p_write_holds_data_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!(strb.acc && strb.isRd)) |=> $stable(rdData));
  p_single_target_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.lowWr, strb.extWr}));
endmodule

// File: rtl/rmAddrRouter.sv
module rmAddrRouter
  import rm_pkg::*;
#(
  parameter int LOW_AW = 10,
  parameter int ROM_AW = 8,
  parameter int EXT_AW = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [15:0]       segIn,
  input  logic [15:0]       offIn,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [7:0]        wrData,
  input  logic              a20En,
  input  logic              romInitEn,
  input  logic [ROM_AW-1:0] romInitAddr,
  input  logic [7:0]        romInitData,
  output logic [7:0]        rdData,
  output logic              ready,
  output logic              unmapped
);
  rmStrobes_t  strb;
  logic [20:0] physAddr;

  rm_ctrl #(.EXT_AW(EXT_AW)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .rdEn      (rdEn),
    .wrEn      (wrEn),
    .romInitEn (romInitEn),
    .physAddr  (physAddr),
    .strb      (strb),
    .ready     (ready),
    .unmapped  (unmapped)
  );

  rm_datapath #(.LOW_AW(LOW_AW), .ROM_AW(ROM_AW), .EXT_AW(EXT_AW)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .segIn       (segIn),
    .offIn       (offIn),
    .a20En       (a20En),
    .wrData      (wrData),
    .romInitAddr (romInitAddr),
    .romInitData (romInitData),
    .strb        (strb),
    .physAddr    (physAddr),
    .rdData      (rdData)
  );
endmodule

// File: tb/rmAddrRouter_tb.sv
module rmAddrRouter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ROM_AW = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [15:0] segIn = '0, offIn = '0;
  logic rdEn = 1'b0, wrEn = 1'b0, a20En = 1'b0, romInitEn = 1'b0;
  logic [7:0] wrData = '0, romInitData = '0;
  logic [ROM_AW-1:0] romInitAddr = '0;
  logic [7:0] rdData;
  logic ready, unmapped;

  int nChecks = 0;
  int nFails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rmAddrRouter #(.LOW_AW(10), .ROM_AW(ROM_AW), .EXT_AW(8)) u_dut (
    .clk(clk), .rstN(rstN), .segIn(segIn), .offIn(offIn), .rdEn(rdEn),
    .wrEn(wrEn), .wrData(wrData), .a20En(a20En), .romInitEn(romInitEn),
    .romInitAddr(romInitAddr), .romInitData(romInitData),
    .rdData(rdData), .ready(ready), .unmapped(unmapped));

  function automatic logic [7:0] romPat(input int k);
    return 8'(k) ^ 8'h5A;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One access: strobes driven at a falling edge, outputs sampled one cycle later.
  task automatic doAcc(input logic [15:0] s, input logic [15:0] o, input logic r,
                       input logic w, input logic [7:0] d,
                       output logic [7:0] rv, output logic rdy, output logic um);
    @(negedge clk);
    segIn = s; offIn = o; rdEn = r; wrEn = w; wrData = d;
    @(negedge clk);
    rv = rdData; rdy = ready; um = unmapped;
    rdEn = 1'b0; wrEn = 1'b0;
  endtask

  task automatic wr(input logic [15:0] s, input logic [15:0] o, input logic [7:0] d,
                    output logic um);
    logic [7:0] rv; logic rdy;
    doAcc(s, o, 1'b0, 1'b1, d, rv, rdy, um);
  endtask

  task automatic rd(input logic [15:0] s, input logic [15:0] o,
                    output logic [7:0] rv, output logic um);
    logic rdy;
    doAcc(s, o, 1'b1, 1'b0, 8'h00, rv, rdy, um);
  endtask

  task automatic testReset();
    check("R10 ready", ready, 0);
    check("R10 unmapped", unmapped, 0);
    check("R10 rdData", rdData, 0);
  endtask

  task automatic testArith();
    logic [7:0] v; logic um;
    wr(16'h1000, 16'h0000, 8'h3C, um);
    rd(16'h0FFF, 16'h0010, v, um);
    check("R1 4096:0 alias", v, 8'h3C);
    wr(16'h1234, 16'h0005, 8'hC7, um);
    rd(16'h1000, 16'h2345, v, um);
    check("R1 0x12345 pair", v, 8'hC7);
  endtask

  task automatic testLow();
    logic [7:0] v; logic um;
    wr(16'h0000, 16'h0010, 8'h11, um);
    wr(16'h0000, 16'h0020, 8'h22, um);
    check("R2 write no pulse", um, 0);
    rd(16'h0000, 16'h0010, v, um);
    check("R2 low read a", v, 8'h11);
    rd(16'h0000, 16'h0020, v, um);
    check("R2 low read b", v, 8'h22);
    check("R2 read no pulse", um, 0);
  endtask

  task automatic testWindows();
    logic [7:0] v; logic um;
    rd(16'hA000, 16'h0000, v, um);
    check("R3 display read data", v, 8'hFF);
    check("R3 display read pulse", um, 1);
    @(negedge clk);
    check("R3 pulse one cycle", unmapped, 0);
    wr(16'h0000, 16'h0040, 8'h44, um);
    wr(16'hC000, 16'h0040, 8'h99, um);   // index 0x040 shares low RAM alias
    check("R3 expansion write pulse", um, 1);
    rd(16'h0000, 16'h0040, v, um);
    check("R3 write ignored", v, 8'h44);
    rd(16'hB800, 16'h0123, v, um);
    check("R3 text window read", v, 8'hFF);
  endtask

  task automatic testRom();
    logic [7:0] v; logic um;
    rd(16'hF000, 16'h0007, v, um);
    check("R4 rom read", v, romPat(7));
    check("R4 rom read no pulse", um, 0);
    wr(16'hF000, 16'h0007, 8'h00, um);
    check("R4 rom write no pulse", um, 0);
    rd(16'hF000, 16'h0007, v, um);
    check("R4 rom unchanged", v, romPat(7));
    rd(16'hF000, 16'hFFFF, v, um);
    check("R4 rom top", v, romPat(255));
  endtask

  task automatic testRomLoadDead();
    logic [7:0] v; logic um;
    @(negedge clk);
    romInitEn = 1'b1; romInitAddr = 8'd3; romInitData = 8'h00;
    @(negedge clk);
    @(negedge clk);
    romInitEn = 1'b0;
    rd(16'hF000, 16'h0003, v, um);
    check("R5 load port dead", v, romPat(3));
  endtask

  task automatic testExt();
    logic [7:0] v; logic um;
    a20En = 1'b0;
    wr(16'h0000, 16'h0000, 8'h5E, um);
    a20En = 1'b1;
    wr(16'hFFFF, 16'h0010, 8'h77, um);
    check("R6 ext write no pulse", um, 0);
    wr(16'hFFFF, 16'h010F, 8'h88, um);
    rd(16'hFFFF, 16'h0010, v, um);
    check("R6 ext read base", v, 8'h77);
    rd(16'hFFFF, 16'h010F, v, um);
    check("R6 ext read top", v, 8'h88);
    rd(16'hFFFF, 16'h0110, v, um);
    check("R6 beyond slice data", v, 8'hFF);
    check("R6 beyond slice pulse", um, 1);
    a20En = 1'b0;
    rd(16'h0000, 16'h0000, v, um);
    check("R6 low intact", v, 8'h5E);
    rd(16'hFFFF, 16'h0010, v, um);
    check("R7 wrap to zero", v, 8'h5E);
    check("R7 wrap no pulse", um, 0);
  endtask

  task automatic testTiming();
    logic [7:0] v; logic um; logic rdy;
    doAcc(16'h0000, 16'h0010, 1'b1, 1'b0, 8'h00, v, rdy, um);
    check("R8 ready after read", rdy, 1);
    @(negedge clk);
    check("R8 ready drops", ready, 0);
    doAcc(16'h0000, 16'h0030, 1'b0, 1'b1, 8'hAB, v, rdy, um);
    check("R8 ready after write", rdy, 1);
    check("R8 rdData held on write", v, 8'h11);
  endtask

  task automatic testBoth();
    logic [7:0] v; logic um; logic rdy;
    doAcc(16'h0000, 16'h0020, 1'b1, 1'b1, 8'hEE, v, rdy, um);
    check("R9 both is read", v, 8'h22);
    rd(16'h0000, 16'h0020, v, um);
    check("R9 no write", v, 8'h22);
  endtask

  initial begin
    // Watchdog
    #(CLK_PERIOD * 20000);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    for (int k = 0; k < (1 << ROM_AW); k++) begin
      @(negedge clk);
      romInitEn = 1'b1; romInitAddr = 8'(k); romInitData = romPat(k);
    end
    @(negedge clk);
    romInitEn = 1'b0;
    testReset();
    @(negedge clk);
    rstN = 1'b1;
    testArith();
    testLow();
    testWindows();
    testRom();
    testRomLoadDead();
    testExt();
    testTiming();
    testBoth();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule